// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block takes a single-wire serial stream, sampled on the rising edge of its own serial clock, and turns it into parallel 16-bit words. The line rests high between frames. A frame opens with a single low START bit. After it comes a run of data words, each sent MSB first and followed by one CHECK bit. Words follow one another with no further START bit. The receiver checks every CHECK bit, then presents the captured word on a parallel output. It raises a one-cycle word strobe, and a one-cycle error flag when the CHECK bit was wrong.

A frame closes with END bits: one full word slot in which all 16 data bits and the CHECK bit are high. A valid word can never look like this, because a word whose last bit is 1 must carry a CHECK bit of 0. The END slot is still presented as a word, with its strobe and a CHECK error. The receiver then drops back to idle. Downstream logic, such as a FIFO or an interrupt handler, must throw away the last word of every frame.

Top module: `framed_word_rx`

## Requirements
- R1: While `rst` is high at a rising `sclk` edge, the block enters idle and clears `rx_word`, `word_valid` and `check_err` to 0.
- R2: In idle, a high `sdi` is ignored: no strobe is produced and the receiver stays in idle.
- R3: In idle, a low `sdi` sampled at an `sclk` edge is the START bit. The next 16 samples are the data word, MSB (bit 15) first.
- R4: On the edge that samples the CHECK bit, `rx_word` takes the 16 captured bits and `word_valid` goes high for exactly one cycle. `rx_word` holds its value until the next word.
- R5: The expected CHECK bit is the inverse of data bit 0. If the received CHECK bit differs from it, `check_err` is high in the same cycle as `word_valid`.
- R6: After a CHECK bit that does not end the frame, the next 16 samples form the next word, with no START bit in between.
- R7: A word slot of 0xFFFF followed by a CHECK bit of 1 is the END pattern. It is presented as word 0xFFFF with both `word_valid` and `check_err` high, and the receiver returns to idle.
- R8: Alternating patterns such as 0xAAAA and 0x5555 are captured exactly, with no bit slip. 0xFFFF with a CHECK bit of 0 is a valid word that keeps the frame open.
- R9: `check_err` is never high without `word_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; `sdi` is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data line, high at rest |
| rx_word | output | 16 | Last word received |
| word_valid | output | 1 | One-cycle strobe: a word has been presented |
| check_err | output | 1 | One-cycle flag: CHECK bit mismatch on the presented word |

## Verification
The assertions assume `sdi` is already synchronised and qualified to `sclk`, so it changes only between rising edges. They also assume the frame structure is never broken in the middle of a word. The stimulus drives `sdi` a fixed 2 ns after each rising edge, one bit per cycle. It always finishes each word slot with its CHECK bit before doing anything else, and it closes every frame with the all-ones END slot. Between frames the line is left high, to show that the idle state ignores it.

// File: rtl/fwr_pkg.sv
package fwr_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_CHECK = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              err;
    } rx_result_t;

    // Expected CHECK bit: the inverse of the last data bit.
    function automatic logic expected_check(input logic last_data_bit);
        return ~last_data_bit;
    endfunction

    // END slot: all data bits high and a high CHECK bit.
    function automatic logic is_end_slot(input logic [WORD_W-1:0] w, input logic chk);
        return (&w) & chk;
    endfunction

endpackage

// File: rtl/fwr_bitcount.sv
module fwr_bitcount #(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last_bit
);
    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_bit = run && (cnt_q == LAST);

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/fwr_shift.sv
module fwr_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              sdi,
    output logic [WORD_W-1:0] shreg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[WORD_W-2:0], sdi};
        end
    end

    // R3
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(shreg));
endmodule

// File: rtl/fwr_fsm.sv
module fwr_fsm
    import fwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sdi,
    input  logic      last_bit,
    input  logic      end_seen,
    output rx_state_t state
);
    rx_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!sdi) nxt = ST_DATA;
            ST_DATA:  if (last_bit) nxt = ST_CHECK;
            ST_CHECK: nxt = end_seen ? ST_IDLE : ST_DATA;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && sdi) |=> (state == ST_IDLE));
    // R7
    end_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && end_seen) |=> (state == ST_IDLE));
    // R6
    next_word_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && !end_seen) |=> (state == ST_DATA));
endmodule

// File: rtl/fwr_result.sv
module fwr_result
    import fwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              sdi,
    input  logic [WORD_W-1:0] shreg,
    output rx_result_t        res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else if (capture) begin
            res.word  <= shreg;
            res.valid <= 1'b1;
            res.err   <= (sdi != expected_check(shreg[0]));
        end else begin
            res.valid <= 1'b0;
            res.err   <= 1'b0;
        end
    end

    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(res.word));
endmodule

// File: rtl/framed_word_rx.sv
module framed_word_rx
    import fwr_pkg::*;
(
    input  logic              sclk,
    input  logic              rst,
    input  logic              sdi,
    output logic [WORD_W-1:0] rx_word,
    output logic              word_valid,
    output logic              check_err
);
    rx_state_t         state;
    logic              last_bit;
    logic              end_seen;
    logic [WORD_W-1:0] shreg;
    rx_result_t        res;

    assign end_seen = (state == ST_CHECK) && is_end_slot(shreg, sdi);

    fwr_bitcount #(.WORD_W(WORD_W)) u_cnt (
        .clk(sclk), .rst(rst), .run(state == ST_DATA), .last_bit(last_bit)
    );

    fwr_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(sclk), .rst(rst), .shift_en(state == ST_DATA), .sdi(sdi), .shreg(shreg)
    );

    fwr_fsm u_fsm (
        .clk(sclk), .rst(rst), .sdi(sdi), .last_bit(last_bit),
        .end_seen(end_seen), .state(state)
    );

    fwr_result u_res (
        .clk(sclk), .rst(rst), .capture(state == ST_CHECK), .sdi(sdi),
        .shreg(shreg), .res(res)
    );

    assign rx_word    = res.word;
    assign word_valid = res.valid;
    assign check_err  = res.err;

    // R9
    err_needs_valid_chk: assert property (@(posedge sclk) disable iff (rst)
        check_err |-> word_valid);
    // R4
    valid_pulse_chk: assert property (@(posedge sclk) disable iff (rst)
        word_valid |=> !word_valid);
    // R4
    valid_after_check_chk: assert property (@(posedge sclk) disable iff (rst)
        word_valid |-> $past(state == ST_CHECK));
endmodule

// File: tb/framed_word_rx_test.sv
`timescale 1ns/1ps
module framed_word_rx_test;
    logic        sclk = 1'b0;
    logic        rst  = 1'b1;
    logic        sdi  = 1'b1;
    logic [15:0] rx_word;
    logic        word_valid;
    logic        check_err;

    int checks = 0;
    int errors = 0;

    framed_word_rx uut (
        .sclk(sclk), .rst(rst), .sdi(sdi),
        .rx_word(rx_word), .word_valid(word_valid), .check_err(check_err)
    );

    always #10 sclk = ~sclk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one bit; it is sampled at the next rising edge; return 2 ns after it.
    task automatic send_bit(input logic b);
        sdi = b;
        @(posedge sclk);
        #2;
    endtask

    // Send 16 data bits MSB first, then the CHECK bit; outputs are valid on return.
    task automatic send_word(input logic [15:0] w, input logic chk);
        for (int i = 15; i >= 0; i--) begin
            send_bit(w[i]);
            if (word_valid !== 1'b0) begin
                checks++; errors++;
                $display("FAIL R4: strobe mid-word actual %b expected 0", word_valid);
            end
        end
        send_bit(chk);
    endtask

    task automatic expect_word(input string tag, input logic [15:0] w, input logic e);
        check({tag, " word"},  {16'h0, rx_word}, {16'h0, w});
        check({tag, " valid"}, {31'h0, word_valid}, 32'd1);
        check({tag, " err"},   {31'h0, check_err}, {31'h0, e});
    endtask

    task automatic t_reset;
        rst = 1'b1; sdi = 1'b1;
        repeat (3) @(posedge sclk);
        #2;
        check("R1 word",  {16'h0, rx_word}, 32'h0);
        check("R1 valid", {31'h0, word_valid}, 32'd0);
        check("R1 err",   {31'h0, check_err}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_idle_ones;
        int seen = 0;
        for (int i = 0; i < 40; i++) begin
            send_bit(1'b1);
            if (word_valid || check_err) seen++;
        end
        check("R2 idle ignores ones", seen, 0);
    endtask

    task automatic end_frame(input string tag);
        send_word(16'hFFFF, 1'b1);
        expect_word({tag, " R7 end"}, 16'hFFFF, 1'b1);
        send_bit(1'b1);
        check({tag, " R4 pulse"}, {31'h0, word_valid}, 32'd0);
    endtask

    task automatic t_single_word;
        send_bit(1'b0);
        send_word(16'h1234, 1'b1);
        expect_word("R3 R5 single", 16'h1234, 1'b0);
        end_frame("single");
    endtask

    task automatic t_check_error;
        send_bit(1'b0);
        send_word(16'h5A5B, 1'b1);
        expect_word("R5 bad check", 16'h5A5B, 1'b1);
        send_word(16'h00F0, 1'b1);
        expect_word("R5 good after bad", 16'h00F0, 1'b0);
        end_frame("err");
    endtask

    task automatic t_back_to_back;
        send_bit(1'b0);
        send_word(16'hAAAA, 1'b1);
        expect_word("R8 aaaa", 16'hAAAA, 1'b0);
        send_word(16'h5555, 1'b0);
        expect_word("R6 R8 5555", 16'h5555, 1'b0);
        send_word(16'hFFFF, 1'b0);
        expect_word("R8 ffff valid", 16'hFFFF, 1'b0);
        send_word(16'h8001, 1'b0);
        expect_word("R6 after ffff", 16'h8001, 1'b0);
        end_frame("b2b");
    endtask

    task automatic t_restart;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        check("R7 idle holds word", {16'h0, rx_word}, 32'h0000FFFF);
        send_bit(1'b0);
        send_word(16'h0001, 1'b0);
        expect_word("R7 new frame", 16'h0001, 1'b0);
        end_frame("restart");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_idle_ones();
                t_single_word();
                t_check_error();
                t_back_to_back();
                t_restart();
            end
            begin
                repeat (20000) @(posedge sclk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule